// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does so by reading two entries from a page table that lives in memory. Pages are 4096 bytes. The twenty page-number bits of the virtual address form two ten-bit indices. The upper index picks an entry in a directory whose base is given with the request. That entry names the frame that holds a second-level table. The lower index then picks an entry in that table, and that entry gives the physical frame. The page offset passes through unchanged.

A requester offers an address together with a directory base. The walker takes it only while it is idle. It then makes at most two word reads on a request/acknowledge memory port. It presents either a physical address or a page fault, and the fault tells which level held the invalid entry. The result is held until the requester acknowledges it. An entry is valid when its bit 0 is set. Bits 31:12 of an entry hold a frame number, and bits 11:1 carry no meaning.

Top module: `two_level_walker`

## Requirements
- R1: Out of reset, req_ready is 1 while mem_req and rsp_valid are both 0.
- R2: The first read goes to dir_base + 4 * vaddr[31:22]. Both dir_base and vaddr are taken from the cycle in which the request is accepted.
- R3: After a valid directory entry E, the second read goes to {E[31:12], 12'h000} + 4 * vaddr[21:12].
- R4: When both entries are valid, the walk ends with rsp_fault = 0 and rsp_paddr = {P[31:12], vaddr[11:0]}, where P is the second-level entry.
- R5: A directory entry with bit 0 clear ends the walk with no second read. The response has rsp_fault = 1, rsp_fault_level = 0 (directory) and rsp_paddr = 0.
- R6: A second-level entry with bit 0 clear gives rsp_fault = 1, rsp_fault_level = 1 (table) and rsp_paddr = 0.
- R7: A memory read stays asserted with an unchanged mem_addr for any number of cycles until mem_ack. The read data is taken in the cycle of mem_ack.
- R8: rsp_valid and the response fields stay constant until rsp_ack. The cycle after the acknowledge, the walker is idle again, with req_ready = 1 and no memory read.
- R9: req_ready is 1 only while idle. A request, or a change to vaddr or dir_base, that is presented while a walk is in progress has no effect on the walk or on what follows it.
- R10: Bits 11:1 of either entry have no effect on addresses, faults or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Byte address of the directory |
| mem_req | output | 1 | Word read in progress |
| mem_addr | output | 32 | Byte address of the word read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result available |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_level | output | 1 | Failing level: 0 directory, 1 table |
| rsp_ack | input | 1 | Requester takes the result |

## Verification
The hardest situation to reach from the ports is a new request that arrives while a walk is in progress, together with a change in the directory base during a slow memory read. Only that case shows whether the walker latched its inputs at acceptance. In the sweep, every few walks the bench drives such a conflicting request and changes the base just after acceptance. It also stretches each read by zero to three cycles. The table contents are an arithmetic function of the address, with faults at both levels spread over all 1024 directory slots and with filler in the ignored entry bits. This lets every walk be predicted without a stored image.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FETCH_DIR = 2'd1,
    ST_FETCH_PTE = 2'd2,
    ST_DONE      = 2'd3
  } walk_state_t;

  typedef enum logic {
    LVL_DIR   = 1'b0,
    LVL_TABLE = 1'b1
  } fault_level_t;

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ENTRY_W   = 32,
  parameter int PAGE_BITS = 12,
  localparam int FRAME_W  = ENTRY_W - PAGE_BITS
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic               present,
  output logic [FRAME_W-1:0] frame
);

  logic spare_unused;

  assign present      = entry[0];
  assign frame        = entry[ENTRY_W-1:PAGE_BITS];
  assign spare_unused = ^entry[PAGE_BITS-1:1];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W      = 32,
  parameter int IDX_W     = 10,
  parameter int PAGE_BITS = 12,
  localparam int FRAME_W  = VA_W - PAGE_BITS,
  localparam int SLOT_SH  = 2
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [VA_W-1:0]    dir_base,
  input  logic [FRAME_W-1:0] table_frame,
  input  logic               sel_table,
  output logic [VA_W-1:0]    rd_addr
);

  logic [IDX_W-1:0] outer_idx;
  logic [IDX_W-1:0] inner_idx;
  logic [VA_W-1:0]  dir_slot_addr;
  logic [VA_W-1:0]  tbl_slot_addr;

  assign outer_idx = vaddr[VA_W-1 -: IDX_W];
  assign inner_idx = vaddr[PAGE_BITS +: IDX_W];

  assign dir_slot_addr = dir_base + VA_W'({outer_idx, {SLOT_SH{1'b0}}});

  generate
    if (PAGE_BITS >= IDX_W + SLOT_SH) begin : g_tbl_concat
      // table frame is page aligned and the slot offset fits in a page
      assign tbl_slot_addr = {table_frame,
                              {(PAGE_BITS - IDX_W - SLOT_SH){1'b0}},
                              inner_idx, {SLOT_SH{1'b0}}};
    end else begin : g_tbl_add
      assign tbl_slot_addr = {table_frame, {PAGE_BITS{1'b0}}}
                           + VA_W'({inner_idx, {SLOT_SH{1'b0}}});
    end
  endgenerate

  assign rd_addr = sel_table ? tbl_slot_addr : dir_slot_addr;

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         mem_ack,
  input  logic         entry_present,
  input  logic         rsp_ack,
  output logic         req_ready,
  output logic         mem_req,
  output logic         sel_table,
  output logic         cap_req,
  output logic         cap_dir,
  output logic         cap_rsp,
  output logic         rsp_fault_nxt,
  output fault_level_t rsp_level_nxt,
  output logic         rsp_valid
);

  walk_state_t state_q, state_d;

  always_comb begin
    state_d       = state_q;
    cap_req       = 1'b0;
    cap_dir       = 1'b0;
    cap_rsp       = 1'b0;
    rsp_fault_nxt = 1'b0;
    rsp_level_nxt = LVL_DIR;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          state_d = ST_FETCH_DIR;
        end
      end
      ST_FETCH_DIR: begin
        if (mem_ack) begin
          if (entry_present) begin
            cap_dir = 1'b1;
            state_d = ST_FETCH_PTE;
          end else begin
            cap_rsp       = 1'b1;
            rsp_fault_nxt = 1'b1;
            rsp_level_nxt = LVL_DIR;
            state_d       = ST_DONE;
          end
        end
      end
      ST_FETCH_PTE: begin
        if (mem_ack) begin
          cap_rsp       = 1'b1;
          rsp_fault_nxt = !entry_present;
          rsp_level_nxt = LVL_TABLE;
          state_d       = ST_DONE;
        end
      end
      ST_DONE: begin
        if (rsp_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_FETCH_DIR) || (state_q == ST_FETCH_PTE);
  assign sel_table = (state_q == ST_FETCH_PTE);
  assign rsp_valid = (state_q == ST_DONE);

  // R9
  idle_only_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);

  // R7
  read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && ($stable(sel_table)));

  // R5
  dir_fault_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !sel_table && mem_ack && !entry_present |=> rsp_valid);

  // R8
  ack_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ack |=> req_ready);

endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int IDX_W     = 10,
  parameter int PAGE_BITS = 12,
  localparam int FRAME_W  = VA_W - PAGE_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [VA_W-1:0] dir_base,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            rsp_fault_level,
  input  logic            rsp_ack
);

  logic [VA_W-1:0]    vaddr_q;
  logic [VA_W-1:0]    base_q;
  logic [FRAME_W-1:0] tframe_q;
  logic [VA_W-1:0]    paddr_q;
  logic               fault_q;
  fault_level_t       level_q;

  logic               entry_present;
  logic [FRAME_W-1:0] entry_frame;
  logic               sel_table;
  logic               cap_req, cap_dir, cap_rsp;
  logic               fault_nxt;
  fault_level_t       level_nxt;
  logic [VA_W-1:0]    paddr_d;

  ptw_entry_decode #(.ENTRY_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_decode (
    .entry   (mem_rdata),
    .present (entry_present),
    .frame   (entry_frame)
  );

  ptw_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .vaddr       (vaddr_q),
    .dir_base    (base_q),
    .table_frame (tframe_q),
    .sel_table   (sel_table),
    .rd_addr     (mem_addr)
  );

  ptw_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_ack       (mem_ack),
    .entry_present (entry_present),
    .rsp_ack       (rsp_ack),
    .req_ready     (req_ready),
    .mem_req       (mem_req),
    .sel_table     (sel_table),
    .cap_req       (cap_req),
    .cap_dir       (cap_dir),
    .cap_rsp       (cap_rsp),
    .rsp_fault_nxt (fault_nxt),
    .rsp_level_nxt (level_nxt),
    .rsp_valid     (rsp_valid)
  );

  always_comb begin
    if (fault_nxt) paddr_d = '0;
    else           paddr_d = {entry_frame, vaddr_q[PAGE_BITS-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      base_q  <= '0;
    end else if (cap_req) begin
      vaddr_q <= req_vaddr;
      base_q  <= dir_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tframe_q <= '0;
    else if (cap_dir) tframe_q <= entry_frame;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
      level_q <= LVL_DIR;
    end else if (cap_rsp) begin
      paddr_q <= paddr_d;
      fault_q <= fault_nxt;
      level_q <= level_nxt;
    end
  end

  assign rsp_paddr       = paddr_q;
  assign rsp_fault       = fault_q;
  assign rsp_fault_level = level_q;

  // R7
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_paddr)
                              && $stable(rsp_fault) && $stable(rsp_fault_level));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[PAGE_BITS-1:0] == vaddr_q[PAGE_BITS-1:0]);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

endmodule

// File: tb/two_level_walker_test.sv
module two_level_walker_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [31:0] DIR_LO = 32'h0040_0000;
  localparam logic [31:0] DIR_HI = 32'h0040_2000;
  localparam logic [31:0] TBL_LO = 32'h0080_0000;
  localparam logic [31:0] TBL_HI = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] dir_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_level;
  logic        rsp_ack = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  two_level_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .dir_base(dir_base),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
    .rsp_ack(rsp_ack)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory image as a function of the word address; bits 11:1 carry filler (R10)
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] i, t, j, fr;
    if (a >= DIR_LO && a < DIR_HI) begin
      i = (a - DIR_LO) >> 2;
      fr = 32'h800 + i;
      return {fr[19:0], 11'((i * 37) & 32'h7FF), (i % 7) != 3};
    end else if (a >= TBL_LO && a < TBL_HI) begin
      t = (a - TBL_LO) >> 12;
      j = (a >> 2) & 32'h3FF;
      fr = (t * 97 + j * 3 + 5) & 32'hFFFFF;
      return {fr[19:0], 11'((t ^ j) & 32'h7FF), ((t + j) % 11) != 5};
    end
    return 32'h0;
  endfunction

  task automatic serve_read(input logic [31:0] exp_addr, input int dly,
                            input string req, output logic [31:0] data);
    int waitc = 0;
    while (!mem_req && waitc < 20) begin
      @(negedge clk);
      waitc++;
    end
    check(mem_req, req, {31'b0, mem_req}, 32'h1);
    check(mem_addr == exp_addr, req, mem_addr, exp_addr);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      check(mem_req && mem_addr == exp_addr, "R7", mem_addr, exp_addr);
    end
    data      = mem_word(mem_addr);
    mem_ack   = 1'b1;
    mem_rdata = data;
    @(negedge clk);
    mem_ack   = 1'b0;
    mem_rdata = 32'h0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input int dly, input bit busy);
    logic [31:0] de, pe, exp_pa, d_addr, t_addr;
    bit exp_fault, exp_lvl;
    check(req_ready, "R9", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1;
    req_vaddr = va;
    dir_base  = base;
    @(negedge clk);
    req_valid = 1'b0;
    if (busy) begin
      req_valid = 1'b1;
      req_vaddr = ~va;
      dir_base  = base ^ 32'h0000_1000;
    end
    check(!req_ready, "R9", {31'b0, req_ready}, 32'h0);
    d_addr = base + {20'b0, va[31:22], 2'b00};
    serve_read(d_addr, dly, "R2", de);
    exp_lvl = 1'b0;
    if (!de[0]) begin
      exp_fault = 1'b1;
      exp_pa    = 32'h0;
      check(!mem_req, "R5", {31'b0, mem_req}, 32'h0);
    end else begin
      t_addr = {de[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
      serve_read(t_addr, (dly + 1) % 4, "R3", pe);
      exp_lvl = 1'b1;
      if (!pe[0]) begin
        exp_fault = 1'b1;
        exp_pa    = 32'h0;
      end else begin
        exp_fault = 1'b0;
        exp_pa    = {pe[31:12], va[11:0]};
      end
    end
    for (int h = 0; h < 2; h++) begin
      check(rsp_valid, "R8", {31'b0, rsp_valid}, 32'h1);
      check(rsp_paddr == exp_pa, exp_fault ? "R5/R6 paddr" : "R4 R10", rsp_paddr, exp_pa);
      check(rsp_fault == exp_fault, exp_lvl ? "R6 fault" : "R5 fault",
            {31'b0, rsp_fault}, {31'b0, exp_fault});
      if (exp_fault)
        check(rsp_fault_level == exp_lvl, exp_lvl ? "R6 level" : "R5 level",
              {31'b0, rsp_fault_level}, {31'b0, exp_lvl});
      check(!req_ready && !mem_req, "R9", {30'b0, req_ready, mem_req}, 32'h0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    rsp_ack   = 1'b1;
    @(negedge clk);
    rsp_ack   = 1'b0;
    check(req_ready && !mem_req && !rsp_valid, "R8 R9",
          {29'b0, req_ready, mem_req, rsp_valid}, 32'h4);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG && !finished) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n = 0;
    logic [31:0] va;
    repeat (3) @(negedge clk);
    check(req_ready && !mem_req && !rsp_valid, "R1",
          {29'b0, req_ready, mem_req, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req && !rsp_valid, "R1",
          {29'b0, req_ready, mem_req, rsp_valid}, 32'h4);
    for (int b = 0; b < 2; b++) begin
      for (int oi = 0; oi < 1024; oi++) begin
        for (int k = 0; k < 2; k++) begin
          int ii, off;
          ii  = (k == 0) ? ((oi * 5) % 1024) : ((oi * 389 + 1023) % 1024);
          off = (oi * 131 + k * 4095) & 12'hFFF;
          va  = {oi[9:0], ii[9:0], off[11:0]};
          walk(va, DIR_LO + b * 32'h1000, n % 4, (n % 5) == 2);
          n++;
        end
      end
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule